// File: doc/BRIEF.md
# Configuration Register Loader with Hidden Sequence Unlock

This block sits between a pseudo-static memory's access port and its array. It holds the 8-bit configuration word that selects refresh coverage, low-power mode, refresh temperature band and page-read enable. The word can be loaded in two ways.

The first way uses the sleep pin. After the pin falls, a write that lands inside a short window is taken as a configuration load. The new value comes from the low address bits, and the write never reaches the array.

The second way is software only. Four ordinary accesses to the top array address unlock the register. Reads, read, write of zero, then write loads the word from the data bus. Reads, read, write of zero, then read returns the word on the data bus. The array word at the top address is never modified by either sequence. Any other access goes to the array unchanged.

Each bus access is presented as a one-clock strobe. Window and gap limits are counted in clock cycles.

Top module: `cfg_unlock`

## Requirements
- R1: After reset the word is 0x70 and the outputs decode it as follows: `par_sel` = bits [2:0] (000 full coverage), `sleep_par` = bit 4 (1 selects partial refresh, 0 deep power-down), `tcr_sel` = bits [6:5] (11 hottest band), `page_en` = bit 7 (0 off). `sw_lock` is 0 after reset.
- R2: A write strobe with `sleep_n` low, arriving WIN_MIN to WIN_MAX cycles after the cycle in which `sleep_n` fell, loads `acc_addr[7:0]` with bit 3 forced to 0 into the word from the next cycle. The write is withheld from the array (`arr_req` low). Only the first such write per fall is taken.
- R3: A write in the fall cycle itself, or later than WIN_MAX cycles after the fall, is an ordinary array write and leaves the word unchanged.
- R4: Read, read, write of 0x0000, then a write, all at MAX_ADDR, loads `acc_wdata` bits [7:5] and [2:0] into the word, with bit 3 cleared and bit 4 (sleep mode) kept. It also sets `sw_lock`.
- R5: Read, read, write of 0x0000, then a read at MAX_ADDR with at least GAP_CYC idle cycles before it, makes `cfg_rd` high in that cycle and `bus_rdata` = {8'h00, word}. Neither the word nor `sw_lock` changes.
- R6: The first two reads of a sequence reach the array. The third and fourth accesses do not (`arr_req` low), so the stored top word is untouched.
- R7: An access to another address, a write at MAX_ADDR out of turn, or a third-step write with nonzero data breaks the sequence and is passed to the array. A read at MAX_ADDR that breaks the sequence counts as a new first read.
- R8: A fourth-step read with fewer than GAP_CYC idle cycles before it is an ordinary array read. `bus_rdata` then equals `arr_rdata`, and the detector restarts with that read as the first.
- R9: When a sleep-pin load and a sequence step fall on the same write, the sleep-pin load wins and the sequence detector returns to its start.
- R10: `sw_lock` stays set until reset. Sleep-pin loads do not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| sleep_n | input | 1 | sleep pin, active low |
| acc_valid | input | 1 | one-cycle access strobe |
| acc_write | input | 1 | 1 write, 0 read |
| acc_addr | input | AW | access address |
| acc_wdata | input | 16 | write data |
| arr_rdata | input | 16 | array read data |
| arr_req | output | 1 | forward this access to the array |
| arr_write | output | 1 | forwarded access is a write |
| bus_rdata | output | 16 | read data returned to the bus |
| cfg_rd | output | 1 | this read returns the configuration word |
| page_en | output | 1 | page-read enable |
| tcr_sel | output | 2 | refresh temperature band |
| sleep_par | output | 1 | sleep mode select |
| par_sel | output | 3 | partial refresh coverage |
| sw_lock | output | 1 | software load has occurred |

## Verification
Two functions can land on the same cycle: the sleep-pin load window and the third step of a software sequence. Both can claim a write of zero at the top address. The bench issues two reads at MAX_ADDR with the pin high, then drops the pin and sends that write inside the window. It then expects the word to take the address bits, the array to see nothing, and the next top-address write to pass through to the array. A cycle-level reference model in the bench is compared with every output on every clock.

// File: rtl/cfg_unlock.sv
module cfg_unlock #(
  parameter int AW = 22,
  parameter logic [AW-1:0] MAX_ADDR = '1,
  parameter int WIN_MIN = 1,
  parameter int WIN_MAX = 25,
  parameter int GAP_CYC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep_n,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [AW-1:0] acc_addr,
  input  logic [15:0]   acc_wdata,
  input  logic [15:0]   arr_rdata,
  output logic          arr_req,
  output logic          arr_write,
  output logic [15:0]   bus_rdata,
  output logic          cfg_rd,
  output logic          page_en,
  output logic [1:0]    tcr_sel,
  output logic          sleep_par,
  output logic [2:0]    par_sel,
  output logic          sw_lock
);
  localparam int WLIM = WIN_MAX + 1;
  localparam int CW = $clog2(WLIM + 1);
  localparam int GW = $clog2(GAP_CYC + 1);

  logic [7:0]    cfg;
  logic          sl_q, used;
  logic [1:0]    step;
  logic [CW-1:0] wcnt;
  logic [GW-1:0] idle;

  logic fall, win, hit, rd, wr, pin_ld, s3w, sw_ld, rdbk, adv;

  assign fall   = sl_q & ~sleep_n;
  assign win    = ~sleep_n & ~fall & ~used &
                  (wcnt >= CW'(WIN_MIN)) & (wcnt <= CW'(WIN_MAX));
  assign hit    = acc_addr == MAX_ADDR;
  assign rd     = acc_valid & ~acc_write;
  assign wr     = acc_valid & acc_write;
  assign pin_ld = wr & win;
  assign s3w    = ~pin_ld & (step == 2'd2) & wr & hit & (acc_wdata == 16'h0000);
  assign sw_ld  = ~pin_ld & (step == 2'd3) & wr & hit;
  assign rdbk   = (step == 2'd3) & rd & hit & (idle == GW'(GAP_CYC));
  assign adv    = (step < 2'd2) & rd & hit;

  assign arr_req   = acc_valid & ~(pin_ld | s3w | sw_ld | rdbk);
  assign arr_write = acc_write;
  assign cfg_rd    = rdbk;
  assign bus_rdata = rdbk ? {8'h00, cfg} : arr_rdata;

  assign page_en   = cfg[7];
  assign tcr_sel   = cfg[6:5];
  assign sleep_par = cfg[4];
  assign par_sel   = cfg[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg     <= 8'h70;
      sw_lock <= 1'b0;
      sl_q    <= 1'b1;
      used    <= 1'b1;
      step    <= 2'd0;
      wcnt    <= CW'(WLIM);
      idle    <= GW'(GAP_CYC);
    end else begin
      sl_q <= sleep_n;

      if (fall)
        wcnt <= CW'(1);
      else if (!sleep_n && wcnt != CW'(WLIM))
        wcnt <= wcnt + 1'b1;

      if (fall)
        used <= 1'b0;
      else if (pin_ld)
        used <= 1'b1;

      if (acc_valid)
        idle <= '0;
      else if (idle != GW'(GAP_CYC))
        idle <= idle + 1'b1;

      if (pin_ld)
        step <= 2'd0;
      else if (acc_valid) begin
        if (adv)                step <= step + 2'd1;
        else if (s3w)           step <= 2'd3;
        else if (sw_ld || rdbk) step <= 2'd0;
        else if (rd && hit)     step <= 2'd1;
        else                    step <= 2'd0;
      end

      if (pin_ld)
        cfg <= {acc_addr[7:4], 1'b0, acc_addr[2:0]};
      else if (sw_ld)
        cfg <= {acc_wdata[7:5], cfg[4], 1'b0, acc_wdata[2:0]};

      if (sw_ld)
        sw_lock <= 1'b1;
    end
  end
endmodule

module cfg_unlock_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        arr_req,
  input logic        cfg_rd,
  input logic [15:0] bus_rdata,
  input logic        page_en,
  input logic [1:0]  tcr_sel,
  input logic        sleep_par,
  input logic [2:0]  par_sel,
  input logic        sw_lock
);
  AST_RDBK_NO_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd |-> !arr_req); // R6
  AST_RDBK_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd |-> bus_rdata[15:8] == 8'h00); // R5
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sw_lock |=> sw_lock); // R10
  AST_SW_KEEPS_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_lock) |-> sleep_par == $past(sleep_par)); // R4
  AST_IDLE_HOLDS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> $stable({page_en, tcr_sel, sleep_par, par_sel})); // R2
  AST_REQ_NEEDS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req |-> acc_valid); // R7
endmodule

bind cfg_unlock cfg_unlock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .arr_req(arr_req),
  .cfg_rd(cfg_rd), .bus_rdata(bus_rdata), .page_en(page_en), .tcr_sel(tcr_sel),
  .sleep_par(sleep_par), .par_sel(par_sel), .sw_lock(sw_lock)
);

// File: tb/sim_cfg_unlock.sv
module sim_cfg_unlock;
  localparam int AW = 22;
  localparam logic [AW-1:0] MAXA = '1;
  localparam int WMIN = 1, WMAX = 25, GAP = 8;

  logic clk = 0, rst_n = 0, sleep_n = 1, acc_valid = 0, acc_write = 0;
  logic [AW-1:0] acc_addr = '0;
  logic [15:0] acc_wdata = '0;
  logic [15:0] arr_rdata = 16'hBEEF;
  logic arr_req, arr_write, cfg_rd, page_en, sleep_par, sw_lock;
  logic [15:0] bus_rdata;
  logic [1:0] tcr_sel;
  logic [2:0] par_sel;

  always #10 clk = ~clk;

  cfg_unlock #(.AW(AW), .MAX_ADDR(MAXA), .WIN_MIN(WMIN), .WIN_MAX(WMAX), .GAP_CYC(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .arr_rdata(arr_rdata), .arr_req(arr_req), .arr_write(arr_write),
    .bus_rdata(bus_rdata), .cfg_rd(cfg_rd), .page_en(page_en), .tcr_sel(tcr_sel),
    .sleep_par(sleep_par), .par_sel(par_sel), .sw_lock(sw_lock));

  int checks = 0, fails = 0;
  string tag = "R1";

  int mcfg = 'h70, mstep = 0, mgap = 1000, mel = 0;
  bit mlock = 0, mprev = 1, mused = 1;

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic tick(bit v, bit w, logic [AW-1:0] a, int d);
    bit fl, wn, ht, pin, s3, swl, rb, xreq;
    int e, xrd;
    acc_valid = v; acc_write = w; acc_addr = a; acc_wdata = d[15:0];
    #1;
    fl  = mprev && !sleep_n;
    e   = fl ? 0 : mel;
    wn  = !sleep_n && !fl && !mused && e >= WMIN && e <= WMAX;
    ht  = a == MAXA;
    pin = v && w && wn;
    s3  = !pin && mstep == 2 && v && w && ht && d == 0;
    swl = !pin && mstep == 3 && v && w && ht;
    rb  = mstep == 3 && v && !w && ht && mgap >= GAP;
    xreq = v && !(pin || s3 || swl || rb);
    xrd  = rb ? mcfg : 'hBEEF;
    check("arr_req", arr_req, xreq);
    if (xreq) check("arr_write", arr_write, w);
    check("cfg_rd", cfg_rd, rb);
    check("bus_rdata", bus_rdata, xrd);
    check("word", {page_en, tcr_sel, sleep_par, 1'b0, par_sel}, mcfg);
    check("sw_lock", sw_lock, mlock);
    if (pin) mcfg = a[7:0] & 'hF7;
    else if (swl) mcfg = (d & 'hE7) | (mcfg & 'h10);
    if (swl) mlock = 1;
    if (pin) mstep = 0;
    else if (v) begin
      if (mstep < 2 && !w && ht) mstep++;
      else if (s3) mstep = 3;
      else if (swl || rb) mstep = 0;
      else if (!w && ht) mstep = 1;
      else mstep = 0;
    end
    mgap = v ? 0 : mgap + 1;
    if (!sleep_n) mel = fl ? 1 : mel + 1;
    if (fl) mused = 0; else if (pin) mused = 1;
    mprev = sleep_n;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(0, 0, '0, 0);
  endtask
  task automatic rd(logic [AW-1:0] a); tick(1, 0, a, 0); endtask
  task automatic wr(logic [AW-1:0] a, int d); tick(1, 1, a, d); endtask

  initial begin
    #200000000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1"; idle(3);
    // R2: load in window
    tag = "R2"; sleep_n = 0; idle(3); wr(22'h00002D, 0); idle(2);
    wr(22'h0000FF, 0); sleep_n = 1; idle(2);
    // R3: too early, then in window; late write
    tag = "R3"; sleep_n = 0; wr(22'h000011, 0); wr(22'h0000D2, 0); sleep_n = 1; idle(2);
    sleep_n = 0; idle(WMAX + 2); wr(22'h000044, 0); sleep_n = 1; idle(2);
    // R4: software load, sleep bit kept (currently 1)
    tag = "R4"; rd(MAXA); rd(MAXA); wr(MAXA, 0); wr(MAXA, 'hFF0A); idle(2);
    // R5: read-back after gap
    tag = "R5"; rd(MAXA); rd(MAXA); wr(MAXA, 0); idle(GAP); rd(MAXA); idle(1);
    // R6: sequence with clear sleep bit via pin first
    tag = "R6"; sleep_n = 0; idle(1); wr(22'h000003, 0); sleep_n = 1;
    rd(MAXA); rd(MAXA); wr(MAXA, 0); wr(MAXA, 'h00B1); idle(2);
    // R7: breaks
    tag = "R7"; rd(MAXA); rd(MAXA); wr(MAXA, 5); wr(MAXA, 'h0077);
    rd(MAXA); rd(22'h000100); rd(MAXA); rd(MAXA); rd(MAXA); wr(MAXA, 0); wr(MAXA, 'h0060);
    wr(MAXA, 'h0012); rd(MAXA); wr(22'h0000AA, 0); idle(2);
    // R8: read-back too soon, then restart completes
    tag = "R8"; rd(MAXA); rd(MAXA); wr(MAXA, 0); idle(GAP - 1); rd(MAXA);
    rd(MAXA); wr(MAXA, 0); idle(GAP + 2); rd(MAXA); idle(1);
    // R9: collision of pin load with third step
    tag = "R9"; rd(MAXA); rd(MAXA); sleep_n = 0; idle(2); wr(MAXA, 0);
    sleep_n = 1; wr(MAXA, 'h0055); idle(2);
    // R10: lock survives pin loads
    tag = "R10"; sleep_n = 0; idle(4); wr(22'h000080, 0); sleep_n = 1; idle(3);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule